// File: doc/BRIEF.md
# Fast 4x4 Luma Intra Mode Decision Controller

This controller runs the 4x4 luma intra mode search for one macroblock. It handles one 4x4 block at a time, addressed by a raster index from 0 to 15 (index = row*4 + column). For each block it builds a candidate set of the nine prediction modes. It requests a cost for each candidate from an external evaluator, which returns the SATD of the residual plus a rate term for the mode bits. It then reports the candidate with the lowest cost. The controller never computes a prediction or a cost itself.

Four fixed positions always search every mode. These are indices 0, 2, 8 and 10, the upper-left block of each 8x8 quadrant. All other blocks search a small set built from the modes of the blocks above and to the left. A partial-search block whose best cost is more than twice the smallest best cost seen so far on a full-search block, within the current macroblock, falls back to searching the modes it skipped. The controller stores every chosen mode, so later blocks inside the macroblock can use it as a neighbour. For neighbours outside the macroblock, the caller supplies the mode and an availability flag.

Top module: `intra4_fast_mode_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `cand_req` are low.
- R2: A block with index 0, 2, 8 or 10 requests all nine modes, 0 to 8, in ascending order.
- R3: Any other block requests the set {above neighbour's mode, left neighbour's mode, 2 (DC)} with duplicates removed, in ascending order. A neighbour inside the macroblock takes the mode last stored for that index. A neighbour outside the macroblock (row 0 for above, column 0 for left) takes the value on the external port. That external mode becomes 2 when its availability flag is low or its code is above 8.
- R4: `done_mode` and `done_cost` give the lowest cost among the modes requested for the block. On a cost tie, the lower mode number wins.
- R5: `mb_start` clears the reference. The reference is then the smallest best cost of the full-search blocks finished since that `mb_start`. A partial-search block whose best cost exceeds twice the reference then requests its skipped modes in ascending order. It reports the minimum over all nine modes, with `done_fallback` high.
- R6: Before any full-search block has finished in the macroblock, no fall-back occurs.
- R7: A best cost exactly equal to twice the reference does not trigger the fall-back.
- R8: `cand_req` and `cand_mode` are held until a cycle with `cost_valid` high. A `cost_valid` pulse while `cand_req` is low is ignored.
- R9: `blk_start` is ignored while `busy` is high. `done` is a one-cycle pulse, after which `busy` is low.
- R10: The threshold comparison does not wrap, even when twice the reference exceeds the range of `COST_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mb_start | input | 1 | Start of a macroblock; clears the reference cost (taken when idle) |
| blk_start | input | 1 | Start the search of one block (taken when idle) |
| blk_idx | input | 4 | Raster index of the block, row*4+column |
| ext_up_avail | input | 1 | Above neighbour outside the macroblock is available |
| ext_up_mode | input | 4 | Mode of that above neighbour |
| ext_left_avail | input | 1 | Left neighbour outside the macroblock is available |
| ext_left_mode | input | 4 | Mode of that left neighbour |
| cand_req | output | 1 | A cost is requested for `cand_mode` |
| cand_mode | output | 4 | Mode whose cost is requested |
| cost_valid | input | 1 | `cost_in` holds the cost of the requested mode |
| cost_in | input | COST_W | Returned cost |
| busy | output | 1 | A block search is in progress |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| done_mode | output | 4 | Chosen mode |
| done_cost | output | COST_W | Cost of the chosen mode |
| done_fallback | output | 1 | The full-search fall-back fired for this block |

## Verification
The search is exercised with uniform cost tables, which isolate the tie rule. It is also run with tables where a skipped mode is much cheaper than the partial candidates, which separates a fall-back from a plain partial search. Costs placed exactly at twice the reference, and references near the top of the cost range, tell apart a strict, non-wrapping compare from a loose or truncated one. External neighbour codes that are valid, invalid or marked unavailable confirm how the candidate set is built. Random macroblocks with random evaluator latency, stray `cost_valid` pulses and `blk_start` pulses while busy check the request order and handshake against a model in the bench.

// File: rtl/intra4_fmd_pkg.sv
package intra4_fmd_pkg;
    localparam int unsigned MODE_W        = 4;
    localparam int unsigned NUM_MODES     = 9;
    localparam int unsigned DC_MODE       = 2;
    localparam int unsigned BLK_PER_SIDE  = 4;
    localparam int unsigned SIDE_W        = $clog2(BLK_PER_SIDE);
    localparam int unsigned NUM_BLK       = BLK_PER_SIDE * BLK_PER_SIDE;
    localparam int unsigned BLK_W         = 2 * SIDE_W;

    typedef logic [MODE_W-1:0] mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_DECIDE = 2'd2
    } fmd_state_e;

    // An external neighbour mode is usable only when flagged and in range.
    function automatic mode_t clean_mode(input logic avail, input mode_t m);
        if (!avail || (m >= mode_t'(NUM_MODES)))
            return mode_t'(DC_MODE);
        return m;
    endfunction
endpackage

// File: rtl/intra4_fmd_cand.sv
module intra4_fmd_cand
    import intra4_fmd_pkg::*;
(
    input  logic                 full_search,
    input  mode_t                up_mode,
    input  mode_t                left_mode,
    output logic [NUM_MODES-1:0] mask
);
    // One bit per mode: set when searched fully, or matched by a neighbour, or DC.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam logic IS_DC = (m == DC_MODE);
        assign mask[m] = full_search
                       | (up_mode   == mode_t'(m))
                       | (left_mode == mode_t'(m))
                       | IS_DC;
    end
endmodule

// File: rtl/intra4_fmd_pick.sv
module intra4_fmd_pick
    import intra4_fmd_pkg::*;
(
    input  logic [NUM_MODES-1:0] pending,
    output logic                 any,
    output mode_t                sel
);
    // Lowest pending mode number wins, giving ascending request order.
    always_comb begin
        sel = '0;
        for (int i = NUM_MODES - 1; i >= 0; i--) begin
            if (pending[i])
                sel = mode_t'(i);
        end
        any = |pending;
    end
endmodule

// File: rtl/intra4_fmd_thresh.sv
module intra4_fmd_thresh #(
    parameter int unsigned COST_W      = 16,
    parameter int unsigned ALPHA_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [COST_W-1:0] upd_cost,
    input  logic [COST_W-1:0] query_cost,
    output logic              exceed
);
    localparam int unsigned XW = COST_W + ALPHA_SHIFT;

    typedef struct packed {
        logic              have;
        logic [COST_W-1:0] fmin;
    } thr_t;

    thr_t s_d, s_q;
    logic [XW-1:0] scaled_ref;
    logic [XW-1:0] query_ext;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.have = 1'b0;
            s_d.fmin = '1;
        end else if (upd) begin
            s_d.have = 1'b1;
            if (!s_q.have || (upd_cost < s_q.fmin))
                s_d.fmin = upd_cost;
        end
        scaled_ref = XW'(s_q.fmin) << ALPHA_SHIFT;
        query_ext  = XW'(query_cost);
        exceed     = s_q.have && (query_ext > scaled_ref);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{have: 1'b0, fmin: '1};
        else        s_q <= s_d;
    end

    // R5
    fmin_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.have && !clr) |=> (s_q.fmin <= $past(s_q.fmin)));

    // R6
    clear_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !exceed);
endmodule

// File: rtl/intra4_fast_mode_ctrl.sv
module intra4_fast_mode_ctrl
    import intra4_fmd_pkg::*;
#(
    parameter int unsigned           COST_W      = 16,
    parameter int unsigned           ALPHA_SHIFT = 1,
    parameter logic [NUM_BLK-1:0]    FULL_POS    = 16'h0505
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mb_start,
    input  logic              blk_start,
    input  logic [BLK_W-1:0]  blk_idx,
    input  logic              ext_up_avail,
    input  logic [MODE_W-1:0] ext_up_mode,
    input  logic              ext_left_avail,
    input  logic [MODE_W-1:0] ext_left_mode,
    output logic              cand_req,
    output logic [MODE_W-1:0] cand_mode,
    input  logic              cost_valid,
    input  logic [COST_W-1:0] cost_in,
    output logic              busy,
    output logic              done,
    output logic [MODE_W-1:0] done_mode,
    output logic [COST_W-1:0] done_cost,
    output logic              done_fallback
);
    typedef struct packed {
        fmd_state_e                st;
        logic [BLK_W-1:0]          idx;
        logic                      full;
        logic                      fell;
        logic [NUM_MODES-1:0]      mask;
        logic [NUM_MODES-1:0]      seen;
        mode_t                     best_mode;
        logic [COST_W-1:0]         best_cost;
        logic                      done;
        mode_t                     out_mode;
        logic [COST_W-1:0]         out_cost;
        logic                      out_fb;
        mode_t [NUM_BLK-1:0]       tbl;
    } ctl_t;

    ctl_t s_d, s_q;

    // Neighbour resolution at block start
    logic [SIDE_W-1:0]    row, col;
    mode_t                up_m, left_m;
    logic                 start_full;
    logic [NUM_MODES-1:0] start_mask;

    assign row        = blk_idx[BLK_W-1:SIDE_W];
    assign col        = blk_idx[SIDE_W-1:0];
    assign start_full = FULL_POS[blk_idx];

    always_comb begin
        if (row != '0)
            up_m = s_q.tbl[blk_idx - BLK_W'(BLK_PER_SIDE)];
        else
            up_m = clean_mode(ext_up_avail, ext_up_mode);
        if (col != '0)
            left_m = s_q.tbl[blk_idx - BLK_W'(1)];
        else
            left_m = clean_mode(ext_left_avail, ext_left_mode);
    end

    intra4_fmd_cand u_cand (
        .full_search (start_full),
        .up_mode     (up_m),
        .left_mode   (left_m),
        .mask        (start_mask)
    );

    // Next candidate
    logic [NUM_MODES-1:0] pending;
    logic                 pend_any;
    mode_t                pick;

    assign pending = s_q.mask & ~s_q.seen;

    intra4_fmd_pick u_pick (
        .pending (pending),
        .any     (pend_any),
        .sel     (pick)
    );

    // Reference threshold
    logic thr_clr, thr_upd, thr_exceed;

    intra4_fmd_thresh #(
        .COST_W      (COST_W),
        .ALPHA_SHIFT (ALPHA_SHIFT)
    ) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (thr_clr),
        .upd        (thr_upd),
        .upd_cost   (s_q.best_cost),
        .query_cost (s_q.best_cost),
        .exceed     (thr_exceed)
    );

    logic better;
    always_comb begin
        better = (s_q.seen == '0)
              || (cost_in < s_q.best_cost)
              || ((cost_in == s_q.best_cost) && (pick < s_q.best_mode));
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        thr_clr  = 1'b0;
        thr_upd  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                thr_clr = mb_start;
                if (blk_start) begin
                    s_d.st        = ST_SCAN;
                    s_d.idx       = blk_idx;
                    s_d.full      = start_full;
                    s_d.mask      = start_mask;
                    s_d.seen      = '0;
                    s_d.fell      = 1'b0;
                    s_d.best_mode = mode_t'(DC_MODE);
                    s_d.best_cost = '1;
                end
            end
            ST_SCAN: begin
                if (!pend_any) begin
                    s_d.st = ST_DECIDE;
                end else if (cost_valid) begin
                    s_d.seen[pick] = 1'b1;
                    if (better) begin
                        s_d.best_mode = pick;
                        s_d.best_cost = cost_in;
                    end
                end
            end
            ST_DECIDE: begin
                if (!s_q.full && !s_q.fell && thr_exceed) begin
                    s_d.st   = ST_SCAN;
                    s_d.fell = 1'b1;
                    s_d.mask = '1;
                end else begin
                    s_d.st             = ST_IDLE;
                    s_d.done           = 1'b1;
                    s_d.out_mode       = s_q.best_mode;
                    s_d.out_cost       = s_q.best_cost;
                    s_d.out_fb         = s_q.fell;
                    s_d.tbl[s_q.idx]   = s_q.best_mode;
                    thr_upd            = s_q.full;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cand_req      = (s_q.st == ST_SCAN) && pend_any;
    assign cand_mode     = pick;
    assign busy          = (s_q.st != ST_IDLE);
    assign done          = s_q.done;
    assign done_mode     = s_q.out_mode;
    assign done_cost     = s_q.out_cost;
    assign done_fallback = s_q.out_fb;

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_req && !cost_valid) |=> (cand_req && $stable(cand_mode)));

    // R3
    cand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_req |-> (cand_mode < mode_t'(NUM_MODES)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_start) |=> $stable(s_q.idx));

    // R5
    fb_partial_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fallback) |-> !s_q.full);

    // R4
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_mode < mode_t'(NUM_MODES)));
endmodule

// File: tb/intra4_fast_mode_ctrl_tb.sv
module intra4_fast_mode_ctrl_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mb_start = 1'b0, blk_start = 1'b0;
    logic [3:0]    blk_idx = '0;
    logic          ext_up_avail = 1'b0, ext_left_avail = 1'b0;
    logic [3:0]    ext_up_mode = '0, ext_left_mode = '0;
    logic          cand_req;
    logic [3:0]    cand_mode;
    logic          cost_valid = 1'b0;
    logic [CW-1:0] cost_in = '0;
    logic          busy, done, done_fallback;
    logic [3:0]    done_mode;
    logic [CW-1:0] done_cost;

    always #5 clk = ~clk;

    intra4_fast_mode_ctrl #(.COST_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .blk_start(blk_start),
        .blk_idx(blk_idx), .ext_up_avail(ext_up_avail), .ext_up_mode(ext_up_mode),
        .ext_left_avail(ext_left_avail), .ext_left_mode(ext_left_mode),
        .cand_req(cand_req), .cand_mode(cand_mode), .cost_valid(cost_valid),
        .cost_in(cost_in), .busy(busy), .done(done), .done_mode(done_mode),
        .done_cost(done_cost), .done_fallback(done_fallback)
    );

    int n_cmp = 0, n_bad = 0;
    int bmodes[16];
    int bfmin = 0;
    bit bhave = 0;
    int cst[9];
    bit wd_hit = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_full(input int idx);
        return (idx == 0) || (idx == 2) || (idx == 8) || (idx == 10);
    endfunction

    function automatic int ext_clean(input bit av, input int m);
        return (av && m < 9) ? m : 2;
    endfunction

    task automatic new_mb();
        @(negedge clk); mb_start = 1'b1;
        @(negedge clk); mb_start = 1'b0;
        bhave = 0;
    endtask

    task automatic run_block(input int idx, input bit ua, input int um,
                             input bit la, input int lm, input bit disturb);
        bit   mask[9];
        int   exp_seq[18], got_seq[18];
        int   en = 0, ng = 0, cyc = 0;
        int   up, lf, best, bm, fb_exp;
        bit   seq_ok;
        up = (idx / 4 != 0) ? bmodes[idx - 4] : ext_clean(ua, um);
        lf = (idx % 4 != 0) ? bmodes[idx - 1] : ext_clean(la, lm);
        for (int m = 0; m < 9; m++)
            mask[m] = is_full(idx) || m == up || m == lf || m == 2;
        best = -1; bm = 0;
        for (int m = 0; m < 9; m++)
            if (mask[m]) begin
                exp_seq[en++] = m;
                if (best < 0 || cst[m] < best) begin best = cst[m]; bm = m; end
            end
        fb_exp = (!is_full(idx) && bhave && best > 2 * bfmin) ? 1 : 0;
        if (fb_exp == 1)
            for (int m = 0; m < 9; m++)
                if (!mask[m]) begin
                    exp_seq[en++] = m;
                    if (cst[m] < best || (cst[m] == best && m < bm)) begin best = cst[m]; bm = m; end
                end
        @(negedge clk);
        blk_start = 1'b1; blk_idx = 4'(idx);
        ext_up_avail = ua; ext_up_mode = 4'(um);
        ext_left_avail = la; ext_left_mode = 4'(lm);
        @(negedge clk);
        blk_start = 1'b0;
        ext_up_avail = 1'($urandom); ext_up_mode = 4'($urandom);
        ext_left_avail = 1'($urandom); ext_left_mode = 4'($urandom);
        forever begin
            cost_valid = 1'b0;
            blk_start  = 1'b0;
            if (done) break;
            if (cand_req) begin
                int cm;
                cm = int'(cand_mode);
                if (ng < 18) got_seq[ng] = cm;
                ng++;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                cost_valid = 1'b1;
                cost_in = CW'(cst[cm < 9 ? cm : 0]);
            end else if ($urandom_range(0, 3) == 0) begin
                cost_valid = 1'b1;   // stray pulse, must be ignored (R8)
                cost_in = '0;
            end
            if (disturb && cyc == 2) begin
                blk_start = 1'b1;    // start while busy, must be ignored (R9)
                blk_idx = 4'(idx ^ 5);
            end
            @(negedge clk);
            cyc++;
            if (cyc > 2000) begin wd_hit = 1; break; end
        end
        cost_valid = 1'b0;
        blk_start = 1'b0;
        if (wd_hit) return;
        seq_ok = (ng == en);
        for (int i = 0; i < en && i < ng; i++)
            if (got_seq[i] != exp_seq[i]) seq_ok = 0;
        if (fb_exp == 1) check(seq_ok, "R5 request order", ng, en);
        else if (is_full(idx)) check(seq_ok, "R2 request order", ng, en);
        else check(seq_ok, "R3 request order", ng, en);
        check(int'(done_mode) == bm, "R4 mode", int'(done_mode), bm);
        check(int'(done_cost) == best, "R4 cost", int'(done_cost), best);
        check(int'(done_fallback) == fb_exp, "R5 fallback flag", int'(done_fallback), fb_exp);
        @(negedge clk);
        check(!done && !busy, "R9 pulse", {done, busy}, 0);
        bmodes[idx] = bm;
        if (is_full(idx)) begin
            if (!bhave || best < bfmin) bfmin = best;
            bhave = 1;
        end
    endtask

    task automatic fill(input int v);
        for (int m = 0; m < 9; m++) cst[m] = v;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        for (int i = 0; i < 16; i++) bmodes[i] = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !cand_req, "R1 reset", {busy, done, cand_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cand_req, "R1 after release", {busy, done, cand_req}, 0);

        // Directed macroblock
        new_mb();
        fill(50); cst[4] = 10;                       // R2: F block, min at 4
        run_block(0, 0, 0, 0, 0, 0);
        fill(60); cst[2] = 100; cst[4] = 90; cst[7] = 5;  // R5: fall-back to 7
        run_block(1, 0, 0, 0, 0, 1);
        fill(30);                                    // R4: tie -> mode 0
        run_block(2, 0, 0, 0, 0, 0);
        fill(1); cst[0] = 20; cst[2] = 20;           // R7: equals 2x ref, R4 tie
        run_block(3, 0, 0, 0, 0, 0);
        for (int i = 4; i < 16; i++) begin
            for (int m = 0; m < 9; m++) cst[m] = $urandom_range(0, 255);
            run_block(i, 0, 0, 0, 0, 0);
        end

        // R6: no full-search block yet
        new_mb();
        fill(1); cst[0] = 200; cst[1] = 200; cst[2] = 200; cst[bmodes[1]] = 200; cst[bmodes[4]] = 200;
        run_block(5, 0, 0, 0, 0, 0);

        // R10: large reference must not wrap; R3 invalid external code
        new_mb();
        fill(40000);
        run_block(0, 1, 3, 1, 3, 0);
        fill(0); cst[2] = 65000; cst[bmodes[0]] = 65000;
        run_block(1, 1, 12, 0, 0, 0);
        fill(100); cst[6] = 3;                       // R3 valid external up mode 6
        run_block(3, 1, 6, 0, 0, 0);

        // Random macroblocks
        for (int mb = 0; mb < 12 && !wd_hit; mb++) begin
            new_mb();
            for (int i = 0; i < 16 && !wd_hit; i++) begin
                int hi;
                hi = ($urandom_range(0, 1) == 1) ? 255 : 63;
                for (int m = 0; m < 9; m++) cst[m] = $urandom_range(0, hi);
                run_block(i, 1'($urandom), $urandom_range(0, 11),
                          1'($urandom), $urandom_range(0, 11), 1'($urandom));
            end
        end

        if (wd_hit) check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule